// File: doc/BRIEF.md
# Serial Display Link Packet Assembler

This block is the transmit side of the protocol layer of a serial display link. A requester hands over one packet request at a time. The request carries a data identifier byte and a 16-bit argument. For a short packet the argument is the parameter pair. For a long packet it is the payload length. The block turns the request into a framed byte stream for the lane layer and pulls the payload bytes of a long packet from a separate byte stream as it needs them.

Each packet goes out as one high-speed burst. A start marker comes first, then the header: the identifier, two argument bytes sent low byte first, and an error-correction byte computed over those three bytes. A long packet then carries its payload and a 16-bit checksum of the payload. An end marker closes the burst. Markers are flagged on a separate control bit so that the lane layer can tell them apart from data. After the end marker the block is idle, which stands for the return to the low-power state, and it can accept the next request.

All three streams use a valid/ready handshake. A stall on the output freezes the frame exactly where it is.

Top module: `dlp_pkt_tx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `req_ready` is 1 and both `out_valid` and `pl_ready` are 0. A reset in the middle of a packet abandons that packet.
- R2: Each accepted request produces exactly one burst, in this order:
  - a start marker (`out_ctrl`=1, `out_data`=0xB8);
  - the packet bytes (`out_ctrl`=0);
  - an end marker (`out_ctrl`=1, `out_data`=0x0E).

  After the end marker the block is idle again.
- R3: A short packet is exactly four bytes: the identifier, `req_arg[7:0]`, `req_arg[15:8]`, then the ECC byte. No payload byte is consumed.
- R4: A long packet is sent as follows:
  - the identifier;
  - the word count, low byte first;
  - the ECC byte;
  - exactly word-count payload bytes;
  - two checksum bytes.
- R5: The ECC byte has bits [7:6] = 0. Bit j of ECC[5:0] is the XOR of the header bits h[i] whose code c(i) has bit j set. The header is h[23:0] = {byte2, byte1, identifier}. c(i) is the i-th value, counting upward from 1, among the 6-bit values with two or more bits set: 3, 5, 6, 7, 9, …, 29.
- R6: The checksum is computed as follows:
  - it is a CRC-16 with polynomial x^16+x^12+x^5+1;
  - the register starts at 0xFFFF;
  - data bits are taken LSB first, over the payload bytes only;
  - there is no final inversion;
  - the result is sent low byte first.

  For the ASCII payload "123456789" the result is 0x6F91.
- R7: A long packet with word count 0 consumes no payload. It carries header and footer, and its footer is 0xFF, 0xFF.
- R8: While `out_valid`=1 and `out_ready`=0, `out_data` and `out_ctrl` hold. No byte is lost or repeated.
- R9: `req_ready` is 1 only while idle. A request held valid during a burst is not taken and does not alter the burst in flight.
- R10: The format is picked by the data type in identifier bits [5:0] only:
  - 0x00–0x0F is short;
  - 0x10–0x3F is long.

  Bits [7:6] (virtual channel) pass through unchanged and do not affect the format.
- R11: `pl_ready` is 1 only in the payload phase and only when `out_ready`=1. Payload bytes leave in the order they arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Packet request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_id | input | 8 | Data identifier: virtual channel [7:6], data type [5:0] |
| req_arg | input | 16 | Parameter pair (short) or word count (long) |
| pl_valid | input | 1 | Payload byte valid |
| pl_ready | output | 1 | Payload byte taken when high with pl_valid |
| pl_data | input | 8 | Payload byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Lane layer accepts the byte |
| out_data | output | 8 | Output byte or marker code |
| out_ctrl | output | 1 | 1 when out_data is a start or end marker |

## Verification
The requests used for testing cover several cases:
- short identifiers with all-zero, all-one and mixed parameters;
- long identifiers with word counts of 0, 1, 9, 17 and 40;
- data types at the 0x0F/0x10 boundary, with virtual-channel bits set.

Comparing frame lengths separates short from long decoding. Single-bit headers pin the ECC code table, and the digit string pins the CRC against a known value. Incrementing and strided payloads expose reordering. Runs with output stalls and gaps in the payload feed are compared byte for byte with runs that have none, which shows whether a stall drops or repeats a byte.

// File: rtl/dlp_pkg.sv
package dlp_pkg;

  localparam int BYTE_W   = 8;
  localparam int DT_W     = 6;
  localparam int HDR_BITS = 24;
  localparam int ECC_BITS = 6;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SOT,
    ST_DI,
    ST_B1,
    ST_B2,
    ST_ECC,
    ST_PAY,
    ST_CK_LO,
    ST_CK_HI,
    ST_EOT
  } tx_state_e;

  // Mask of header bits feeding ECC bit j: header bit i is assigned the
  // i-th 6-bit code (ascending) that has at least two bits set.
  function automatic logic [HDR_BITS-1:0] ecc_mask(input int j);
    logic [HDR_BITS-1:0] m;
    logic [ECC_BITS-1:0] code;
    int idx;
    m   = '0;
    idx = 0;
    for (int v = 1; v < (1 << ECC_BITS); v++) begin
      code = ECC_BITS'(v);
      if (($countones(code) >= 2) && (idx < HDR_BITS)) begin
        m[idx] = code[j];
        idx++;
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/dlp_ecc_gen.sv
module dlp_ecc_gen
  import dlp_pkg::*;
(
  input  logic [HDR_BITS-1:0] hdr_i,
  output logic [BYTE_W-1:0]   ecc_o
);

  for (genvar j = 0; j < ECC_BITS; j++) begin : g_par
    localparam logic [HDR_BITS-1:0] MASK = ecc_mask(j);
    assign ecc_o[j] = ^(hdr_i & MASK);
  end

  for (genvar k = ECC_BITS; k < BYTE_W; k++) begin : g_zero
    assign ecc_o[k] = 1'b0;
  end

endmodule

// File: rtl/dlp_crc16.sv
module dlp_crc16
  import dlp_pkg::*;
#(
  parameter logic [15:0] POLY_REV = 16'h8408,
  parameter logic [15:0] INIT     = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              en_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [15:0]       crc_o
);

  logic [15:0] crc_q;
  logic [15:0] crc_d;
  logic [15:0] step;

  always_comb begin
    step = crc_q;
    for (int b = 0; b < BYTE_W; b++) begin
      if (step[0] ^ data_i[b]) begin
        step = (step >> 1) ^ POLY_REV;
      end else begin
        step = step >> 1;
      end
    end
  end

  always_comb begin
    crc_d = crc_q;
    if (clear_i) begin
      crc_d = INIT;
    end else if (en_i) begin
      crc_d = step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= INIT;
    end else if (clear_i || en_i) begin
      crc_q <= crc_d;
    end
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/dlp_seq.sv
module dlp_seq
  import dlp_pkg::*;
#(
  parameter int WC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid_i,
  input  logic            req_long_i,
  input  logic [WC_W-1:0] req_wc_i,
  input  logic            pl_valid_i,
  input  logic            out_ready_i,
  output logic            req_ready_o,
  output logic            pl_ready_o,
  output logic            out_valid_o,
  output logic            capture_o,
  output logic            pay_fire_o,
  output tx_state_e       state_o
);

  tx_state_e       state_q, state_d;
  logic [WC_W-1:0] cnt_q, cnt_d;
  logic            long_q, long_d;
  logic            fire;

  assign req_ready_o = (state_q == ST_IDLE);
  assign capture_o   = req_ready_o && req_valid_i;
  assign out_valid_o = (state_q != ST_IDLE) && ((state_q != ST_PAY) || pl_valid_i);
  assign fire        = out_valid_o && out_ready_i;
  assign pl_ready_o  = (state_q == ST_PAY) && out_ready_i;
  assign pay_fire_o  = (state_q == ST_PAY) && fire;
  assign state_o     = state_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    long_d  = long_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          state_d = ST_SOT;
          cnt_d   = req_wc_i;
          long_d  = req_long_i;
        end
      end
      ST_SOT: if (fire) state_d = ST_DI;
      ST_DI:  if (fire) state_d = ST_B1;
      ST_B1:  if (fire) state_d = ST_B2;
      ST_B2:  if (fire) state_d = ST_ECC;
      ST_ECC: begin
        if (fire) begin
          if (!long_q) begin
            state_d = ST_EOT;
          end else if (cnt_q == '0) begin
            state_d = ST_CK_LO;
          end else begin
            state_d = ST_PAY;
          end
        end
      end
      ST_PAY: begin
        if (fire) begin
          cnt_d = cnt_q - WC_W'(1);
          if (cnt_q == WC_W'(1)) begin
            state_d = ST_CK_LO;
          end
        end
      end
      ST_CK_LO: if (fire) state_d = ST_CK_HI;
      ST_CK_HI: if (fire) state_d = ST_EOT;
      ST_EOT:   if (fire) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      long_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      long_q  <= long_d;
    end
  end

endmodule

// File: rtl/dlp_byte_mux.sv
module dlp_byte_mux
  import dlp_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SOT_CODE = 8'hB8,
  parameter logic [BYTE_W-1:0] EOT_CODE = 8'h0E
) (
  input  tx_state_e           state_i,
  input  logic [HDR_BITS-1:0] hdr_i,
  input  logic [BYTE_W-1:0]   ecc_i,
  input  logic [BYTE_W-1:0]   pl_data_i,
  input  logic [15:0]         crc_i,
  output logic [BYTE_W-1:0]   data_o,
  output logic                ctrl_o
);

  always_comb begin
    data_o = '0;
    ctrl_o = 1'b0;
    unique case (state_i)
      ST_SOT: begin
        data_o = SOT_CODE;
        ctrl_o = 1'b1;
      end
      ST_DI:    data_o = hdr_i[7:0];
      ST_B1:    data_o = hdr_i[15:8];
      ST_B2:    data_o = hdr_i[23:16];
      ST_ECC:   data_o = ecc_i;
      ST_PAY:   data_o = pl_data_i;
      ST_CK_LO: data_o = crc_i[7:0];
      ST_CK_HI: data_o = crc_i[15:8];
      ST_EOT: begin
        data_o = EOT_CODE;
        ctrl_o = 1'b1;
      end
      default: begin
        data_o = '0;
        ctrl_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/dlp_pkt_tx.sv
module dlp_pkt_tx
  import dlp_pkg::*;
#(
  parameter int                WC_W        = 16,
  parameter logic [DT_W-1:0]   LONG_DT_MIN = 6'h10,
  parameter logic [BYTE_W-1:0] SOT_CODE    = 8'hB8,
  parameter logic [BYTE_W-1:0] EOT_CODE    = 8'h0E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BYTE_W-1:0] req_id,
  input  logic [WC_W-1:0]   req_arg,
  input  logic              pl_valid,
  output logic              pl_ready,
  input  logic [BYTE_W-1:0] pl_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_ctrl
);

  localparam int ARG_BYTES = WC_W / BYTE_W;

  tx_state_e           state;
  logic                capture;
  logic                pay_fire;
  logic                req_long;
  logic [HDR_BITS-1:0] hdr_in;
  logic [HDR_BITS-1:0] hdr_q, hdr_d;
  logic [BYTE_W-1:0]   ecc_in;
  logic [BYTE_W-1:0]   ecc_q, ecc_d;
  logic [15:0]         crc;

  assign req_long = (req_id[DT_W-1:0] >= LONG_DT_MIN);
  assign hdr_in   = {req_arg[ARG_BYTES*BYTE_W-1:0], req_id};

  dlp_seq #(.WC_W(WC_W)) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid),
    .req_long_i  (req_long),
    .req_wc_i    (req_arg),
    .pl_valid_i  (pl_valid),
    .out_ready_i (out_ready),
    .req_ready_o (req_ready),
    .pl_ready_o  (pl_ready),
    .out_valid_o (out_valid),
    .capture_o   (capture),
    .pay_fire_o  (pay_fire),
    .state_o     (state)
  );

  dlp_ecc_gen i_ecc (
    .hdr_i (hdr_in),
    .ecc_o (ecc_in)
  );

  dlp_crc16 i_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (capture),
    .en_i    (pay_fire),
    .data_i  (pl_data),
    .crc_o   (crc)
  );

  always_comb begin
    hdr_d = hdr_q;
    ecc_d = ecc_q;
    if (capture) begin
      hdr_d = hdr_in;
      ecc_d = ecc_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q <= '0;
      ecc_q <= '0;
    end else if (capture) begin
      hdr_q <= hdr_d;
      ecc_q <= ecc_d;
    end
  end

  dlp_byte_mux #(
    .SOT_CODE (SOT_CODE),
    .EOT_CODE (EOT_CODE)
  ) i_mux (
    .state_i   (state),
    .hdr_i     (hdr_q),
    .ecc_i     (ecc_q),
    .pl_data_i (pl_data),
    .crc_i     (crc),
    .data_o    (out_data),
    .ctrl_o    (out_ctrl)
  );

endmodule

// File: rtl/dlp_pkt_tx_chk.sv
module dlp_pkt_tx_chk #(
  parameter logic [7:0] SOT_CODE = 8'hB8,
  parameter logic [7:0] EOT_CODE = 8'h0E
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       pl_valid,
  input logic       pl_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_ctrl
);

  logic [3:0] pos_q;
  logic       fire;

  assign fire = out_valid && out_ready;

  // Byte position within the burst: 0 = start marker, 4 = ECC byte.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= 4'hF;
    end else if (fire) begin
      if (out_ctrl && (out_data == SOT_CODE)) begin
        pos_q <= 4'd1;
      end else if (pos_q != 4'hF) begin
        pos_q <= pos_q + 4'd1;
      end
    end
  end

  AST_SOT_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (out_valid && out_ctrl && (out_data == SOT_CODE))); // R2

  AST_MARKER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ctrl) |-> ((out_data == SOT_CODE) || (out_data == EOT_CODE))); // R2

  AST_ECC_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (pos_q == 4'd4)) |-> (!out_ctrl && (out_data[7:6] == 2'b00))); // R5

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ctrl))); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!out_valid && !pl_ready)); // R9

  AST_PL_READY_PAY: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready |-> (out_ready && !out_ctrl && (out_valid == pl_valid))); // R11

endmodule

bind dlp_pkt_tx dlp_pkt_tx_chk #(
  .SOT_CODE (SOT_CODE),
  .EOT_CODE (EOT_CODE)
) i_dlp_pkt_tx_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .pl_valid  (pl_valid),
  .pl_ready  (pl_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_ctrl  (out_ctrl)
);

// File: tb/test_dlp_pkt_tx.sv
`timescale 1ns/1ps
module test_dlp_pkt_tx;

  localparam logic [7:0] SOT = 8'hB8;
  localparam logic [7:0] EOT = 8'h0E;

  // Header bit i -> 6-bit ECC code (R5)
  localparam logic [5:0] CODE [24] = '{
    6'd3,  6'd5,  6'd6,  6'd7,  6'd9,  6'd10, 6'd11, 6'd12,
    6'd13, 6'd14, 6'd15, 6'd17, 6'd18, 6'd19, 6'd20, 6'd21,
    6'd22, 6'd23, 6'd24, 6'd25, 6'd26, 6'd27, 6'd28, 6'd29
  };

  // {id, arg, payload seed, payload step, stall}
  localparam int NV = 8;
  localparam logic [40:0] VECS [NV] = '{
    {8'h05, 16'h1234, 8'h00, 8'h00, 1'b0},
    {8'hC0, 16'hFFFF, 8'h00, 8'h00, 1'b1},
    {8'h29, 16'd9,    8'h31, 8'h01, 1'b0},
    {8'h39, 16'd0,    8'h00, 8'h00, 1'b1},
    {8'h5E, 16'd17,   8'hA5, 8'h3B, 1'b1},
    {8'h4F, 16'h0102, 8'h00, 8'h00, 1'b0},
    {8'h90, 16'd1,    8'h00, 8'h00, 1'b0},
    {8'h2C, 16'd40,   8'h03, 8'h05, 1'b1}
  };

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic       req_ready;
  logic [7:0] req_id;
  logic [15:0] req_arg;
  logic       pl_valid;
  logic       pl_ready;
  logic [7:0] pl_data;
  logic       out_valid;
  logic       out_ready;
  logic [7:0] out_data;
  logic       out_ctrl;

  int errors;
  int checks;
  logic [8:0] expq [0:63];
  logic [8:0] got  [0:63];
  int n_exp;
  int n_got;
  int pl_taken;
  int busy_seen;

  dlp_pkt_tx i_dlp_pkt_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_id    (req_id),
    .req_arg   (req_arg),
    .pl_valid  (pl_valid),
    .pl_ready  (pl_ready),
    .pl_data   (pl_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_ctrl  (out_ctrl)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] ecc_ref(input logic [23:0] h);
    logic [5:0] e;
    e = '0;
    for (int i = 0; i < 24; i++) if (h[i]) e ^= CODE[i];
    return {2'b00, e};
  endfunction

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int b = 0; b < 8; b++) begin
      fb = r[0] ^ d[b];
      r  = r >> 1;
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  function automatic bit is_long(input logic [7:0] id);
    return id[5:0] >= 6'h10;
  endfunction

  function automatic string tag_for(input int pos, input int n, input bit lng, input int wc);
    if (pos == 0 || pos == n - 1) return "R2";
    if (pos <= 3) return lng ? "R4" : "R3";
    if (pos == 4) return "R5";
    if (pos < 5 + wc) return "R11";
    return (wc == 0) ? "R7" : "R6";
  endfunction

  task automatic build(input logic [7:0] id, input logic [15:0] arg,
                       input logic [7:0] seed, input logic [7:0] step);
    logic [15:0] c;
    logic [7:0]  b;
    int wc;
    wc = is_long(id) ? int'(arg) : 0;
    n_exp = 0;
    expq[n_exp++] = {1'b1, SOT};
    expq[n_exp++] = {1'b0, id};
    expq[n_exp++] = {1'b0, arg[7:0]};
    expq[n_exp++] = {1'b0, arg[15:8]};
    expq[n_exp++] = {1'b0, ecc_ref({arg, id})};
    if (is_long(id)) begin
      c = 16'hFFFF;
      for (int k = 0; k < wc; k++) begin
        b = seed + 8'(k) * step;
        c = crc_byte(c, b);
        expq[n_exp++] = {1'b0, b};
      end
      expq[n_exp++] = {1'b0, c[7:0]};
      expq[n_exp++] = {1'b0, c[15:8]};
    end
    expq[n_exp++] = {1'b1, EOT};
  endtask

  task automatic run_pkt(input logic [7:0] id, input logic [15:0] arg,
                         input logic [7:0] seed, input logic [7:0] step,
                         input bit stall, input bit probe);
    int  wc;
    int  cyc;
    bit  accepted;
    bit  acc_now;
    bit  plv;
    wc = is_long(id) ? int'(arg) : 0;
    build(id, arg, seed, step);
    @(negedge clk);
    req_id = id; req_arg = arg; req_valid = 1'b1;
    accepted = 0; plv = 0; cyc = 0;
    n_got = 0; pl_taken = 0; busy_seen = 0;
    while (n_got < n_exp && cyc < 3000) begin
      out_ready = stall ? ((cyc % 3) != 1) : 1'b1;
      if (!plv) plv = (pl_taken < wc) && (!stall || (cyc % 4) != 2);
      pl_valid = plv;
      pl_data  = seed + 8'(pl_taken) * step;
      #1;
      acc_now = req_valid && req_ready && !accepted;
      if (accepted && req_ready) busy_seen++;
      if (out_valid && out_ready) begin
        got[n_got] = {out_ctrl, out_data};
        chk(got[n_got] == expq[n_got], tag_for(n_got, n_exp, is_long(id), wc),
            $sformatf("byte %0d", n_got), int'(got[n_got]), int'(expq[n_got]));
        n_got++;
      end
      if (pl_valid && pl_ready) begin
        pl_taken++;
        plv = 0;
      end
      @(negedge clk);
      cyc++;
      if (acc_now) begin
        accepted = 1;
        if (probe) begin
          req_id = 8'h3F; req_arg = 16'hDEAD;
        end else begin
          req_valid = 1'b0;
        end
      end
    end
    req_valid = 1'b0;
    pl_valid  = 1'b0;
    out_ready = 1'b1;
    chk(n_got == n_exp, "R2", "burst length", n_got, n_exp);
    chk(pl_taken == wc, is_long(id) ? "R4" : "R3", "payload consumed", pl_taken, wc);
    chk(busy_seen == 0, "R9", "req_ready while busy", busy_seen, 0);
    #1;
    chk(req_ready && !out_valid, "R2", "idle after end marker",
        {req_ready, out_valid}, 2'b10);
  endtask

  initial begin
    errors = 0; checks = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_id = '0; req_arg = '0;
    pl_valid = 1'b0; pl_data = '0; out_ready = 1'b1;
    #1;
    chk(req_ready && !out_valid && !pl_ready, "R1", "state in reset",
        {req_ready, out_valid, pl_ready}, 3'b100);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(req_ready && !out_valid && !pl_ready, "R1", "state after reset",
        {req_ready, out_valid, pl_ready}, 3'b100);

    // Table walk: every byte compared against the reference frame
    for (int v = 0; v < NV; v++) begin
      run_pkt(VECS[v][40:33], VECS[v][32:17], VECS[v][16:9], VECS[v][8:1],
              VECS[v][0], 1'b0);
    end

    // R5: single-bit headers pin individual codes
    run_pkt(8'h01, 16'h0000, 8'h00, 8'h00, 1'b0, 1'b0);
    chk(got[4] == 9'h003, "R5", "ECC of header bit 0", int'(got[4]), 3);
    run_pkt(8'h00, 16'h8000, 8'h00, 8'h00, 1'b0, 1'b0);
    chk(got[4] == 9'h01D, "R5", "ECC of header bit 23", int'(got[4]), 29);

    // R6: digit string gives a known checksum
    run_pkt(8'h29, 16'd9, 8'h31, 8'h01, 1'b1, 1'b0);
    chk({got[15][7:0], got[14][7:0]} == 16'h6F91, "R6", "CRC of 123456789",
        int'({got[15][7:0], got[14][7:0]}), 16'h6F91);

    // R7: empty long packet
    run_pkt(8'h1A, 16'd0, 8'h00, 8'h00, 1'b0, 1'b0);
    chk(n_got == 8 && got[5] == 9'h0FF && got[6] == 9'h0FF, "R7",
        "zero-count footer", int'({got[6][7:0], got[5][7:0]}), 16'hFFFF);

    // R10: channel bits pass unchanged; 0x0F short, 0x10 long
    run_pkt(8'hCF, 16'h5A5A, 8'h00, 8'h00, 1'b0, 1'b0);
    chk(n_got == 6 && got[1] == 9'h0CF, "R10", "dt 0x0F short, id kept",
        n_got, 6);
    run_pkt(8'hD0, 16'd2, 8'h77, 8'h11, 1'b0, 1'b0);
    chk(n_got == 10 && got[1] == 9'h0D0, "R10", "dt 0x10 long, id kept",
        n_got, 10);

    // R8: heavy stall on a long packet, full compare inside run_pkt
    run_pkt(8'h3E, 16'd25, 8'hF0, 8'h09, 1'b1, 1'b0);

    // R9: a second request held during a burst is not taken
    run_pkt(8'h12, 16'd3, 8'h40, 8'h02, 1'b0, 1'b1);

    // R1: reset mid-packet abandons the burst
    @(negedge clk);
    req_id = 8'h2A; req_arg = 16'd4; req_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(req_ready && !out_valid && !pl_ready, "R1", "reset mid-packet",
        {req_ready, out_valid, pl_ready}, 3'b100);
    @(negedge clk);
    rst_n = 1'b1;
    run_pkt(8'h07, 16'hBEEF, 8'h00, 8'h00, 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule